// File: doc/BRIEF.md
# Burst Read Master

This block accepts read commands on a user side (start address, beat count, latency-mode bit, valid/ready) and turns each one into one or more incrementing read bursts on the AR and R channels of an AXI bus. Returned beats land in an internal synchronous FIFO. The FIFO feeds the user through a valid/ready stream. When the last beat of a command has arrived, the block pulses a success output. If any beat of the command carried an error response, it pulses an error output instead.

The data width equals the bus width, and command addresses must be aligned to it. Each command picks one of two modes. In the patient mode, an address phase waits until the FIFO can hold every beat of that burst, so the bus never sees RREADY stalls. In the eager mode, the address phase goes out at once, and FIFO back-pressure reaches the bus through RREADY. The read path stands alone, and no write channel is involved.

Top module: `rd_burst_master`

## Requirements
- R1: A command is cut into bursts of at most MAX_BEATS beats, at consecutive word addresses starting at the command address. Each burst has ar_len_o equal to its beat count minus one, ar_burst_o = 2'b01 (incrementing), and ar_size_o = log2 of the bytes per word. Address and length stay stable while ar_valid_o waits for ar_ready_i.
- R2: No burst crosses a 4096-byte address boundary. A command that straddles one is cut at the boundary.
- R3: For a command with cmd_fast_i = 0, a burst's address phase is issued only when the current FIFO fill, plus the beats of all issued but not yet received bursts, plus this burst, is at most DEPTH. While such a burst returns, r_ready_o stays high.
- R4: r_ready_o is high exactly when the FIFO holds fewer than DEPTH words. A command with cmd_fast_i = 1 issues its bursts regardless of FIFO fill.
- R5: cmd_ready_o is high after reset. It goes low in the cycle after a command with a non-zero beat count is accepted. It comes back high in the cycle after the last address phase of that command is accepted.
- R6: No address phase is issued while MAX_OPEN bursts have been issued and have not yet returned their RLAST beat.
- R7: done_o pulses for one cycle, in the cycle after the RLAST beat of a command's last burst is accepted, provided every beat of the command returned r_resp_i[1] = 0.
- R8: If any beat of a command returns r_resp_i[1] = 1 (SLVERR or DECERR), err_o pulses in place of done_o, at the same time. done_o and err_o are never high together.
- R9: Read data reaches rd_data_o in bus order. rd_valid_o is high whenever the FIFO is non-empty. rd_data_o holds its value while rd_valid_o is high and rd_ready_i is low.
- R10: A command with a beat count of zero is accepted and produces no address phase and no pulse.
- R11: During reset, cmd_ready_o and r_ready_o are high, and ar_valid_o, rd_valid_o, done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_addr_i | input | ADDR_W | Start address of command, word aligned |
| cmd_beats_i | input | SIZE_W | Number of words to read |
| cmd_fast_i | input | 1 | 1: eager issue, 0: issue only with FIFO room reserved |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready |
| rd_data_o | output | DATA_W | Read data toward user |
| rd_valid_o | output | 1 | Read data valid |
| rd_ready_i | input | 1 | User accepts read data |
| done_o | output | 1 | Command finished without error (pulse) |
| err_o | output | 1 | Command finished with an error response (pulse) |
| ar_addr_o | output | ADDR_W | Burst address |
| ar_len_o | output | 8 | Burst length minus one |
| ar_size_o | output | 3 | log2 of bytes per beat |
| ar_burst_o | output | 2 | Burst type, incrementing |
| ar_valid_o | output | 1 | Address valid |
| ar_ready_i | input | 1 | Address ready |
| r_data_i | input | DATA_W | Returned beat data |
| r_resp_i | input | 2 | Beat response |
| r_last_i | input | 1 | Last beat of burst |
| r_valid_i | input | 1 | Beat valid |
| r_ready_o | output | 1 | Beat ready, FIFO not full |

## Verification
The hardest case to reach is a patient-mode command that has to wait for space. That requires a full FIFO while earlier bursts are still reserved and in flight. The stimulus gets there by holding rd_ready_i low, issuing one patient command that exactly fills the FIFO, and then issuing a second. The model checks, at every address handshake, that fill plus reservation plus burst length stays within the depth, and only then releases the reader. The same approach is repeated with eager commands into a full FIFO, with a slave that stalls its beats to push the outstanding-burst count to its limit, and with a command that straddles a 4096-byte boundary.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } iss_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_SLV   = 2'b10;
  localparam logic [1:0] RESP_DEC   = 2'b11;

  function automatic logic resp_bad(logic [1:0] resp);
    return (resp == RESP_SLV) || (resp == RESP_DEC);
  endfunction
endpackage

// File: rtl/rdm_fifo.sv
module rdm_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign do_push = push_i && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);
  assign head_o  = mem_q[rptr_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= bump(wptr_q);
      if (do_pop)  rptr_q <= bump(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q < CNT_W'(DEPTH));

  // R9
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && !pop_i |=> $stable(head_o));
endmodule

// File: rtl/rdm_track.sv
module rdm_track #(
  parameter int MAX_OPEN = 4,
  localparam int OPEN_W  = $clog2(MAX_OPEN + 1),
  localparam int PW      = (MAX_OPEN > 1) ? $clog2(MAX_OPEN) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       iss_fire_i,
  input  logic       iss_last_i,
  input  logic       beat_fire_i,
  input  logic       beat_last_i,
  input  logic [1:0] beat_resp_i,
  output logic       open_full_o,
  output logic       done_o,
  output logic       err_o
);
  import rdm_pkg::*;

  logic [MAX_OPEN-1:0] tail_q;
  logic [PW-1:0]       wptr_q, rptr_q;
  logic [OPEN_W-1:0]   cnt_q;
  logic                acc_err_q, done_q, err_q;
  logic                close, bad;

  assign open_full_o = (cnt_q == OPEN_W'(MAX_OPEN));
  assign close       = beat_fire_i && beat_last_i && (cnt_q != '0);
  assign bad         = acc_err_q || (beat_fire_i && resp_bad(beat_resp_i));
  assign done_o      = done_q;
  assign err_o       = err_q;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(MAX_OPEN - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q    <= '0;
      wptr_q    <= '0;
      rptr_q    <= '0;
      cnt_q     <= '0;
      acc_err_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (iss_fire_i) begin
        tail_q[wptr_q] <= iss_last_i;
        wptr_q         <= bump(wptr_q);
      end
      if (close) rptr_q <= bump(rptr_q);
      case ({iss_fire_i, close})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (close && tail_q[rptr_q]) begin
        done_q    <= !bad;
        err_q     <= bad;
        acc_err_q <= 1'b0;
      end else begin
        acc_err_q <= bad;
      end
    end
  end

  // R6
  open_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_fire_i |-> cnt_q < OPEN_W'(MAX_OPEN));

  // R7
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(beat_fire_i && beat_last_i));

  // R8
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o && $past(beat_fire_i && beat_last_i));
endmodule

// File: rtl/rdm_issue.sv
module rdm_issue #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 16,
  parameter int OFFS      = 2,
  parameter int MAX_BEATS = 16,
  parameter int DEPTH     = 32,
  parameter int CNT_W     = 6,
  parameter int RES_W     = 7,
  localparam int PAGE_WORDS = 4096 >> OFFS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [SIZE_W-1:0] cmd_beats_i,
  input  logic              cmd_fast_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [CNT_W-1:0]  fifo_cnt_i,
  input  logic              open_full_i,
  input  logic              beat_fire_i,
  output logic [ADDR_W-1:0] ar_addr_o,
  output logic [7:0]        ar_len_o,
  output logic              ar_valid_o,
  input  logic              ar_ready_i,
  output logic              iss_fire_o,
  output logic              iss_last_o
);
  import rdm_pkg::*;

  iss_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] remain_q;
  logic              fast_q;
  logic [RES_W-1:0]  resv_q;
  logic [31:0]       page_left, lim, need;
  logic              space_ok, fire;

  always_comb begin
    page_left = 32'(PAGE_WORDS) - 32'(addr_q[11:OFFS]);
    lim = 32'(remain_q);
    if (lim > 32'(MAX_BEATS)) lim = 32'(MAX_BEATS);
    if (lim > page_left)      lim = page_left;
    need = 32'(fifo_cnt_i) + 32'(resv_q) + lim;
  end

  assign space_ok    = fast_q || (need <= 32'(DEPTH));
  assign cmd_ready_o = (state_q == ST_IDLE);
  assign ar_valid_o  = (state_q == ST_ISSUE) && space_ok && !open_full_i;
  assign ar_addr_o   = addr_q;
  assign ar_len_o    = 8'(lim - 32'd1);
  assign fire        = ar_valid_o && ar_ready_i;
  assign iss_fire_o  = fire;
  assign iss_last_o  = (lim == 32'(remain_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
      fast_q   <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (cmd_valid_i && (cmd_beats_i != '0)) begin
        addr_q   <= cmd_addr_i;
        remain_q <= cmd_beats_i;
        fast_q   <= cmd_fast_i;
        state_q  <= ST_ISSUE;
      end
    end else if (fire) begin
      addr_q   <= addr_q + ADDR_W'(lim << OFFS);
      remain_q <= remain_q - SIZE_W'(lim);
      if (iss_last_o) state_q <= ST_IDLE;
    end
  end

  // space promised to issued bursts, released beat by beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) resv_q <= '0;
    else resv_q <= resv_q + (fire ? RES_W'(lim) : '0) - (beat_fire_i ? RES_W'(1) : '0);
  end

  // R1
  ar_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o && !ar_ready_i |=> ar_valid_o && $stable(ar_addr_o) && $stable(ar_len_o));

  // R2
  page_cross_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o |-> (32'(ar_addr_o[11:OFFS]) + 32'(ar_len_o)) < 32'(PAGE_WORDS));

  // R5
  ready_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && iss_last_o |=> cmd_ready_o);
endmodule

// File: rtl/rd_burst_master.sv
module rd_burst_master #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SIZE_W    = 16,
  parameter int MAX_BEATS = 16,
  parameter int MAX_OPEN  = 4,
  parameter int DEPTH     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [SIZE_W-1:0] cmd_beats_i,
  input  logic              cmd_fast_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] ar_addr_o,
  output logic [7:0]        ar_len_o,
  output logic [2:0]        ar_size_o,
  output logic [1:0]        ar_burst_o,
  output logic              ar_valid_o,
  input  logic              ar_ready_i,
  input  logic [DATA_W-1:0] r_data_i,
  input  logic [1:0]        r_resp_i,
  input  logic              r_last_i,
  input  logic              r_valid_i,
  output logic              r_ready_o
);
  import rdm_pkg::*;

  localparam int OFFS  = $clog2(DATA_W / 8);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int RES_W = $clog2(MAX_OPEN * MAX_BEATS + DEPTH + 1);

  logic [CNT_W-1:0] fifo_cnt;
  logic             beat_fire, iss_fire, iss_last, open_full;

  assign r_ready_o  = (fifo_cnt != CNT_W'(DEPTH));
  assign beat_fire  = r_valid_i && r_ready_o;
  assign rd_valid_o = (fifo_cnt != '0);
  assign ar_size_o  = 3'(OFFS);
  assign ar_burst_o = BURST_INCR;

  rdm_issue #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFFS(OFFS), .MAX_BEATS(MAX_BEATS),
    .DEPTH(DEPTH), .CNT_W(CNT_W), .RES_W(RES_W)
  ) u_issue (
    .clk_i, .rst_ni,
    .cmd_addr_i, .cmd_beats_i, .cmd_fast_i, .cmd_valid_i, .cmd_ready_o,
    .fifo_cnt_i (fifo_cnt),
    .open_full_i(open_full),
    .beat_fire_i(beat_fire),
    .ar_addr_o, .ar_len_o, .ar_valid_o, .ar_ready_i,
    .iss_fire_o (iss_fire),
    .iss_last_o (iss_last)
  );

  rdm_track #(.MAX_OPEN(MAX_OPEN)) u_track (
    .clk_i, .rst_ni,
    .iss_fire_i (iss_fire),
    .iss_last_i (iss_last),
    .beat_fire_i(beat_fire),
    .beat_last_i(r_last_i),
    .beat_resp_i(r_resp_i),
    .open_full_o(open_full),
    .done_o, .err_o
  );

  rdm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i     (beat_fire),
    .push_data_i(r_data_i),
    .pop_i      (rd_valid_o && rd_ready_i),
    .head_o     (rd_data_o),
    .cnt_o      (fifo_cnt)
  );

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));
endmodule

// File: tb/rd_burst_master_bench.sv
module rd_burst_master_bench;
  localparam int AW = 32, DW = 32, SW = 8, MB = 4, MO = 2, DEP = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] cmd_addr = '0;
  logic [SW-1:0] cmd_beats = '0;
  logic cmd_fast = 1'b0, cmd_valid = 1'b0, cmd_ready;
  logic [DW-1:0] rd_data;
  logic rd_valid, rd_ready = 1'b0, done, err;
  logic [AW-1:0] ar_addr;
  logic [7:0] ar_len;
  logic [2:0] ar_size;
  logic [1:0] ar_burst;
  logic ar_valid, ar_ready = 1'b0;
  logic [DW-1:0] r_data = '0;
  logic [1:0] r_resp = '0;
  logic r_last = 1'b0, r_valid = 1'b0, r_ready;

  rd_burst_master #(.ADDR_W(AW), .DATA_W(DW), .SIZE_W(SW), .MAX_BEATS(MB),
                    .MAX_OPEN(MO), .DEPTH(DEP)) u_rd_burst_master (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_addr_i(cmd_addr), .cmd_beats_i(cmd_beats), .cmd_fast_i(cmd_fast),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
    .done_o(done), .err_o(err),
    .ar_addr_o(ar_addr), .ar_len_o(ar_len), .ar_size_o(ar_size),
    .ar_burst_o(ar_burst), .ar_valid_o(ar_valid), .ar_ready_i(ar_ready),
    .r_data_i(r_data), .r_resp_i(r_resp), .r_last_i(r_last),
    .r_valid_i(r_valid), .r_ready_o(r_ready)
  );

  int vectors = 0, fails = 0, cycle = 0;
  bit wd_hit = 0;
  int eq_addr[$], eq_len[$];
  bit eq_fast[$], eq_last[$];
  int sq_addr[$], sq_len[$];
  bit sq_fast[$], sq_last[$];
  int sl_idx = 0;
  int rdq[$];
  int occ = 0, resv = 0, outst = 0, pend = 0;
  bit exp_done = 0, exp_err = 0, cur_err = 0;
  int ar_mode = 0, r_mode = 0, rd_mode = 1;
  localparam int ERR_ADDR = 'h2008;
  bit want_cmd = 0, clr_cmd = 0, accepted = 0;
  int w_addr = 0, w_beats = 0;
  bit w_fast = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  task automatic split(int a, int n, bit f);
    int rem = n, cur = a;
    while (rem > 0) begin
      int pg = (4096 - (cur % 4096)) / 4;
      int c = rem;
      if (c > MB) c = MB;
      if (c > pg) c = pg;
      eq_addr.push_back(cur); eq_len.push_back(c - 1);
      eq_fast.push_back(f);   eq_last.push_back(c == rem);
      for (int i = 0; i < c; i++) rdq.push_back(cur + 4 * i);
      pend++;
      rem -= c;
      cur += 4 * c;
    end
  endtask

  task automatic step();
    bit cf, af, rf, df, nd, ne;
    @(negedge clk);
    if (clr_cmd) begin cmd_valid = 1'b0; clr_cmd = 0; end
    if (want_cmd) begin
      cmd_valid = 1'b1; cmd_addr = AW'(w_addr); cmd_beats = SW'(w_beats);
      cmd_fast = w_fast; want_cmd = 0;
    end
    ar_ready = (ar_mode != 0) ? 1'($urandom_range(1, 0)) : 1'b1;
    rd_ready = (rd_mode == 0) ? 1'b0 : (rd_mode == 1) ? 1'b1 : 1'($urandom_range(1, 0));
    if (sq_addr.size() > 0) begin
      int a = sq_addr[0] + 4 * sl_idx;
      r_valid = (r_mode != 0) ? 1'($urandom_range(3, 0) == 0) : 1'b1;
      r_data  = DW'(a);
      r_last  = (sl_idx == sq_len[0]);
      r_resp  = (a == ERR_ADDR) ? 2'b10 : 2'b00;
    end else begin
      r_valid = 1'b0; r_last = 1'b0; r_resp = 2'b00;
    end
    #1;
    cycle++;
    if (cycle > 150000) wd_hit = 1;
    cf = cmd_valid && cmd_ready;
    af = ar_valid && ar_ready;
    rf = r_valid && r_ready;
    df = rd_valid && rd_ready;
    chk(cmd_ready == (pend == 0), "R5 cmd_ready", int'(cmd_ready), int'(pend == 0));
    chk(r_ready == (occ < DEP), "R4 r_ready", int'(r_ready), int'(occ < DEP));
    chk(rd_valid == (occ > 0), "R9 rd_valid", int'(rd_valid), int'(occ > 0));
    if (rd_valid && rdq.size() > 0) chk(rd_data == DW'(rdq[0]), "R9 rd_data", int'(rd_data), rdq[0]);
    chk(done == exp_done, "R7 done", int'(done), int'(exp_done));
    chk(err == exp_err, "R8 err", int'(err), int'(exp_err));
    if (outst >= MO) chk(!ar_valid, "R6 open limit", int'(ar_valid), 0);
    if (r_valid && sq_addr.size() > 0 && !sq_fast[0])
      chk(r_ready, "R3 no stall", int'(r_ready), 1);
    nd = 0; ne = 0;
    if (af) begin
      if (eq_addr.size() == 0) chk(0, "R10 unexpected AR", int'(ar_addr), -1);
      else begin
        chk(ar_addr == AW'(eq_addr[0]), "R1 ar_addr", int'(ar_addr), eq_addr[0]);
        chk(int'(ar_len) == eq_len[0], "R1 ar_len", int'(ar_len), eq_len[0]);
        chk(ar_burst == 2'b01 && ar_size == 3'd2, "R1 burst/size", int'({ar_burst, ar_size}), 'h0a);
        chk(((int'(ar_addr) % 4096) / 4 + int'(ar_len)) < 1024, "R2 page", int'(ar_addr), eq_addr[0]);
        if (!eq_fast[0])
          chk(occ + resv + int'(ar_len) + 1 <= DEP, "R3 space", occ + resv + int'(ar_len) + 1, DEP);
        sq_addr.push_back(eq_addr[0]); sq_len.push_back(eq_len[0]);
        sq_fast.push_back(eq_fast[0]); sq_last.push_back(eq_last[0]);
        resv += eq_len[0] + 1;
        void'(eq_addr.pop_front()); void'(eq_len.pop_front());
        void'(eq_fast.pop_front()); void'(eq_last.pop_front());
        pend--; outst++;
      end
    end
    if (rf) begin
      occ++; resv--;
      if (r_resp[1]) cur_err = 1;
      if (r_last) begin
        if (sq_last[0]) begin nd = !cur_err; ne = cur_err; cur_err = 0; end
        void'(sq_addr.pop_front()); void'(sq_len.pop_front());
        void'(sq_fast.pop_front()); void'(sq_last.pop_front());
        sl_idx = 0; outst--;
      end else sl_idx++;
    end
    if (df) begin occ--; void'(rdq.pop_front()); end
    if (cf) begin
      accepted = 1; clr_cmd = 1;
      split(int'(cmd_addr), int'(cmd_beats), cmd_fast);
    end
    exp_done = nd; exp_err = ne;
  endtask

  task automatic send(int a, int n, bit f);
    w_addr = a; w_beats = n; w_fast = f; want_cmd = 1; accepted = 0;
    while (!accepted && !wd_hit) step();
  endtask

  task automatic wait_idle();
    while (!wd_hit && !(pend == 0 && outst == 0 && occ == 0 && eq_addr.size() == 0
                        && !exp_done && !exp_err && !clr_cmd)) step();
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset values
    chk(cmd_ready && r_ready, "R11 reset ready", int'({cmd_ready, r_ready}), 3);
    chk(!ar_valid && !rd_valid, "R11 reset valid", int'({ar_valid, rd_valid}), 0);
    chk(!done && !err, "R11 reset pulses", int'({done, err}), 0);
    rst_ni = 1'b1;
    step();
    // R1 split, patient mode
    rd_mode = 1; ar_mode = 1;
    send('h100, 10, 0); wait_idle();
    // R2 4K straddle
    send('hFF8, 6, 0); wait_idle();
    // R10 zero beats
    send('h400, 0, 0); repeat (10) step();
    // R3 patient command must wait for FIFO room
    rd_mode = 0; ar_mode = 0;
    send('h800, 8, 0); send('h900, 4, 0);
    repeat (40) step();
    rd_mode = 2; wait_idle();
    // R4 eager commands into a full FIFO
    rd_mode = 0;
    send('hA00, 8, 1); send('hB00, 8, 1);
    repeat (30) step();
    rd_mode = 2; wait_idle();
    // R8 error response, followed by a clean command (R7)
    rd_mode = 1; ar_mode = 1;
    send('h2000, 10, 0); send('h3000, 5, 1); wait_idle();
    // R6 outstanding limit with a slow slave
    r_mode = 1; ar_mode = 0;
    send('h5000, 12, 1); send('h6000, 9, 0); wait_idle();
    r_mode = 0;
    if (wd_hit) begin
      fails++;
      $display("FAIL R7 watchdog actual=hung expected=idle");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule